// File: doc/BRIEF.md
# Microcode Sequence Merge Unit

This unit sits between a decoded micro-op trace store and the execution back end. Each incoming trace entry is either an ordinary micro-op or a tag. A tag stands in for a long instruction whose micro-ops are not stored in the trace; it carries the address where that instruction's sequence begins in a constant ROM inside the unit. When a tag reaches the head of the trace stream, the unit takes it, holds the trace source off, and plays the ROM words out one after another until it reaches the word marked as the last one. The trace entry behind the tag then follows.

Downstream sees a single valid/ready micro-op stream with nothing that shows where each micro-op came from. Back-pressure rules: `out_valid` never drops and `out_uop` never changes while `out_ready` is low, except in the cycle after a `flush`. On the input side, a transfer happens in any cycle where `in_valid` and `in_ready` are both high. `in_ready` may depend on `in_kind`, because a tag needs no room in the output stage. A `flush` pulse throws away the ROM sequence in progress and the micro-op held at the output, and hands control back to the trace source.

Top module: `useq_merge`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 while `flush` is low.
- R2: A trace entry with `in_kind` = 0 is a micro-op. It is output once, unchanged, in stream order.
- R3: A trace entry with `in_kind` = 1 is a tag. `in_data[7:0]` gives the ROM start address. The tag itself is never output. In its place, the ROM words from the start address upward are output in address order, up to and including the first word whose last flag is set.
- R4: ROM word at address a holds the micro-op {a XOR 8'hC3, a}: the upper byte is a XOR 8'hC3 and the lower byte is a. Its last flag is set when a[1:0] = 2'b11. A sequence that starts at address s is therefore 4 − s[1:0] words long.
- R5: From the cycle after a tag is accepted until its last ROM word has been loaded into the output stage, `in_ready` is 0. The next output after the sequence is the trace entry that followed the tag.
- R6: When `out_ready` is held high and the output stage is empty, a tag accepted in cycle t gives `out_valid` = 0 in cycle t+1. The first ROM micro-op appears in cycle t+2, and each further word follows in the next cycle.
- R7: While `out_valid` = 1 and `out_ready` = 0 (and no flush), `out_valid` and `out_uop` hold their values into the next cycle.
- R8: While `flush` is 1, `in_ready` is 0. In the next cycle, `out_valid` is 0 and no micro-op from the abandoned sequence or the discarded output is ever issued. The next trace entry is accepted normally.
- R9: With `out_ready` held high, back-to-back trace micro-ops are accepted one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Abort ROM sequence and clear output stage |
| in_valid | input | 1 | Trace entry valid |
| in_ready | output | 1 | Trace entry accepted when high together with in_valid |
| in_kind | input | 1 | 0 = micro-op, 1 = ROM tag |
| in_data | input | UOP_W (16) | Micro-op, or ROM start address in bits [ADDR_W-1:0] for a tag |
| out_valid | output | 1 | Output micro-op valid |
| out_ready | input | 1 | Consumer accepts output micro-op |
| out_uop | output | UOP_W (16) | Output micro-op |

## Verification
The hardest situation to reach from the ports is a flush that arrives while a ROM sequence is only partly issued and the output stage is stalled with a micro-op in it. The stimulus builds this case on purpose: `out_ready` is held low, a trace micro-op is pushed in, then a tag, and the flush comes a few cycles later. The reference model then expects only the micro-op sent after the flush. Long random runs, with `out_ready` low about a third of the time and tags on about a third of the entries, drive the handoff in both directions while the output is back-pressured. This covers back-to-back tags and tags that point at a last word.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic {
    KIND_UOP = 1'b0,
    KIND_TAG = 1'b1
  } entry_kind_e;

  typedef enum logic {
    ST_TRACE = 1'b0,
    ST_ROM   = 1'b1
  } seq_state_e;

  // XOR pattern applied to the upper half of each ROM micro-op
  localparam logic [7:0] ROM_MASK = 8'hC3;
endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int UOP_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [UOP_W-1:0]  rd_uop,
  output logic              rd_last
);
  import useq_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int ENT_W = UOP_W + 1;

  logic [ENT_W-1:0] table_w [DEPTH];
  logic [ENT_W-1:0] word_q;

  // Constant content computed per address: {last, micro-op}
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [ADDR_W-1:0] A = ADDR_W'(i);
    assign table_w[i] = {(A[1:0] == 2'b11),
                         UOP_W'({A ^ ADDR_W'(ROM_MASK), A})};
  end

  // One-cycle synchronous read
  always_ff @(posedge clk) begin
    if (!rst_n)     word_q <= '0;
    else if (rd_en) word_q <= table_w[rd_addr];
  end

  assign rd_uop  = word_q[UOP_W-1:0];
  assign rd_last = word_q[UOP_W];
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic              in_kind,
  input  logic [ADDR_W-1:0] tag_addr,
  input  logic              can_load,
  input  logic              word_last,
  output logic              in_ready,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rom_load,
  output logic              rom_active
);
  import useq_pkg::*;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              word_vld_q;
  logic              tag_hs;

  assign in_ready   = !flush && (state_q == ST_TRACE) &&
                      ((in_kind == KIND_TAG) || can_load);
  assign tag_hs     = in_valid && in_ready && (in_kind == KIND_TAG);
  assign rom_active = (state_q == ST_ROM);
  assign rom_load   = rom_active && word_vld_q && can_load && !flush;
  assign rd_en      = tag_hs || (rom_load && !word_last);
  assign rd_addr    = tag_hs ? tag_addr : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      state_q    <= ST_TRACE;
      ptr_q      <= '0;
      word_vld_q <= 1'b0;
    end else if (tag_hs) begin
      state_q    <= ST_ROM;
      ptr_q      <= tag_addr + 1'b1;
      word_vld_q <= 1'b1;
    end else if (rom_load) begin
      if (word_last) begin
        state_q    <= ST_TRACE;
        word_vld_q <= 1'b0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/useq_outreg.sv
module useq_outreg #(
  parameter int UOP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic [UOP_W-1:0] load_uop,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [UOP_W-1:0] out_uop,
  output logic             can_load
);
  logic             valid_q;
  logic [UOP_W-1:0] uop_q;

  assign can_load  = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_uop   = uop_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= 1'b0;
      uop_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      uop_q   <= load_uop;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/useq_merge.sv
module useq_merge #(
  parameter int UOP_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_kind,
  input  logic [UOP_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [UOP_W-1:0] out_uop
);
  import useq_pkg::*;

  logic              can_load;
  logic              rom_load;
  logic              rom_active;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [UOP_W-1:0]  rom_uop;
  logic              rom_last;
  logic              trace_load;
  logic              load;
  logic [UOP_W-1:0]  load_uop;

  useq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .tag_addr  (in_data[ADDR_W-1:0]),
    .can_load  (can_load),
    .word_last (rom_last),
    .in_ready  (in_ready),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rom_load  (rom_load),
    .rom_active(rom_active)
  );

  useq_rom #(.UOP_W(UOP_W), .ADDR_W(ADDR_W)) u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_uop (rom_uop),
    .rd_last(rom_last)
  );

  assign trace_load = in_valid && in_ready && (in_kind == KIND_UOP);
  assign load       = trace_load || rom_load;
  assign load_uop   = rom_load ? rom_uop : in_data;

  useq_outreg #(.UOP_W(UOP_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load     (load),
    .load_uop (load_uop),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_uop  (out_uop),
    .can_load (can_load)
  );
endmodule

// File: rtl/useq_merge_chk.sv
module useq_merge_chk #(
  parameter int UOP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_kind,
  input logic             out_valid,
  input logic             out_ready,
  input logic [UOP_W-1:0] out_uop,
  input logic             rom_active
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_uop));

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rom_active |-> !in_ready);

  assert_tag_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_kind && !flush |=> rom_active);

  assert_flush_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !rom_active);

  assert_flush_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);
endmodule

bind useq_merge useq_merge_chk #(.UOP_W(UOP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_kind   (in_kind),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_uop   (out_uop),
  .rom_active(rom_active)
);

// File: tb/useq_merge_tb.sv
module useq_merge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int UOP_W  = 16;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_kind = 1'b0;
  logic [UOP_W-1:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [UOP_W-1:0] out_uop;

  useq_merge #(.UOP_W(UOP_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_uop(out_uop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [UOP_W-1:0] exp_q[$];
  bit src_q[$];
  int rom_left = 0;
  bit prev_hold = 0;
  bit prev_flush = 0;
  bit last_in_hs = 0;
  logic [UOP_W-1:0] prev_uop = '0;

  function automatic logic [UOP_W-1:0] rom_uop(input logic [7:0] a);
    return {a ^ 8'hC3, a};
  endfunction

  function automatic int rom_len(input logic [7:0] a);
    return 4 - int'(a[1:0]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      summary();
      $finish;
    end
  end

  // One clock cycle: observe mid-cycle, update model, move to next negedge
  task automatic cycle();
    logic [UOP_W-1:0] e;
    bit s;
    #1;
    last_in_hs = 0;
    if (flush) begin
      check(!in_ready, "R8", "in_ready during flush", in_ready, 0);
      exp_q.delete();
      src_q.delete();
      rom_left = 0;
    end else begin
      if (prev_flush) check(!out_valid, "R8", "out_valid after flush", out_valid, 0);
      if (prev_hold)
        check(out_valid && out_uop == prev_uop, "R7", "held output", out_uop, prev_uop);
      if (rom_left >= 2) check(!in_ready, "R5", "in_ready during ROM", in_ready, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected output", out_uop, 0);
        end else begin
          e = exp_q.pop_front();
          s = src_q.pop_front();
          if (s) rom_left--;
          check(out_uop == e, s ? "R3" : "R2", "output order/value", out_uop, e);
        end
      end
      last_in_hs = in_valid && in_ready;
      if (last_in_hs) begin
        if (!in_kind) begin
          exp_q.push_back(in_data);
          src_q.push_back(1'b0);
        end else begin
          for (int k = 0; k < rom_len(in_data[7:0]); k++) begin
            exp_q.push_back(rom_uop(in_data[7:0] + 8'(k)));
            src_q.push_back(1'b1);
          end
          rom_left += rom_len(in_data[7:0]);
        end
      end
    end
    prev_hold  = out_valid && !out_ready && !flush;
    prev_uop   = out_uop;
    prev_flush = flush;
    @(negedge clk);
  endtask

  task automatic send(input bit kind, input logic [UOP_W-1:0] d);
    in_valid = 1'b1;
    in_kind  = kind;
    in_data  = d;
    cycle();
    while (!last_in_hs) cycle();
    in_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (n) cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready, "R1", "in_ready after reset", in_ready, 1);
    @(negedge clk);

    // Random mix of micro-ops and tags under back-pressure (R2, R3, R4, R5, R7)
    for (int c = 0; c < 6000; c++) begin
      if (!in_valid || last_in_hs) begin
        if ($urandom_range(9) < 8) begin
          in_valid = 1'b1;
          in_kind  = ($urandom_range(9) < 3);
          in_data  = UOP_W'($urandom);
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = ($urandom_range(9) < 7);
      cycle();
    end
    drain(12);
    check(exp_q.size() == 0, "R5", "all entries issued after random run", exp_q.size(), 0);

    // R3/R4 boundary: tags pointing at a last word, back to back, with uop between
    send(1'b1, 16'h00FF);
    send(1'b1, 16'h0003);
    send(1'b0, 16'h5555);
    send(1'b1, 16'h00FE);
    drain(10);
    check(exp_q.size() == 0, "R3", "boundary tags drained", exp_q.size(), 0);

    // R6: latency of the handoff with an empty output stage
    out_ready = 1'b1;
    in_valid = 1'b1; in_kind = 1'b1; in_data = 16'h0010;
    cycle();
    check(last_in_hs, "R6", "tag accepted", last_in_hs, 1);
    in_valid = 1'b0;
    check(!out_valid, "R6", "bubble cycle", out_valid, 0);
    cycle();
    for (int k = 0; k < 4; k++) begin
      check(out_valid && out_uop == rom_uop(8'(16 + k)), "R6", "ROM word timing",
            out_uop, rom_uop(8'(16 + k)));
      cycle();
    end
    check(!out_valid, "R6", "sequence ended", out_valid, 0);

    // R9: one trace micro-op per cycle
    out_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_kind = 1'b0; in_data = UOP_W'(16'h7000 + i);
      cycle();
      check(last_in_hs, "R9", "back-to-back accept", last_in_hs, 1);
    end
    drain(4);

    // R8: flush during a partly issued ROM sequence with a stalled output
    out_ready = 1'b0;
    send(1'b0, 16'h1234);
    send(1'b1, 16'h0020);
    for (int i = 0; i < 3; i++) begin
      check(!in_ready, "R5", "stall before flush", in_ready, 0);
      cycle();
    end
    flush = 1'b1;
    cycle();
    flush = 1'b0;
    check(!out_valid, "R8", "output cleared by flush", out_valid, 0);
    out_ready = 1'b1;
    in_valid = 1'b1; in_kind = 1'b0; in_data = 16'hBEEF;
    cycle();
    check(last_in_hs, "R8", "trace accepted after flush", last_in_hs, 1);
    in_valid = 1'b0;
    check(out_valid && out_uop == 16'hBEEF, "R8", "first output after flush", out_uop, 16'hBEEF);
    drain(6);
    check(exp_q.size() == 0 && !out_valid, "R8", "nothing left after flush", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule